// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block merges the interrupt conditions of a serial port into one interrupt request line and an 8-bit identification byte. The byte names the most urgent source that is waiting. There are four classes of source. In order of urgency they are: receive line errors; received data or a character timeout; an empty transmit holding register; and a change on the modem status lines. Each class has its own enable bit. The receive, line-error and modem conditions arrive as levels from logic around the block, and that logic also clears them. The transmit-empty condition is an event, so the block holds it in a pending flag of its own. Software clears that flag by reading the identification byte while transmit-empty is the source it shows, or by writing a new character.

The upper bits of the identification byte show whether the buffered (FIFO) mode is on. A character timeout is recognised only in that mode. The request line and the identification byte both come from registers, so the request line never glitches, and both follow their inputs one clock later.

Top module: `uart_irq_ident`

## Requirements
- R1: The class order from most to least urgent is line error, then receive (data ready or timeout), then transmit empty, then modem change. The byte always reports the most urgent enabled class that is active.
- R2: Bit 0 of the byte is 0 when any enabled source is pending and 1 when none is. `irq` is high exactly when bit 0 is 0.
- R3: The low nibble is 0x6 for a line error, 0x4 for data ready, 0x2 for transmit empty, 0x0 for a modem change, and 0x1 when nothing is pending.
- R4: A character timeout gives low nibble 0xC, but only while `fifo_mode` is 1. Without FIFO mode the timeout input is ignored. When data ready and timeout are both active in FIFO mode, the timeout code is shown.
- R5: Bits 5 and 4 of the byte are always 0.
- R6: Bits 7 and 6 are both 1 when `fifo_mode` is 1 and both 0 otherwise.
- R7: Enable bit 0 gates the receive class, bit 1 transmit empty, bit 2 line error and bit 3 modem change. With all four enables at 0, `irq` is 0 and the byte reads 0x01 or 0xC1.
- R8: A transmit-empty interrupt becomes pending when `thr_empty` rises while enable bit 1 is set, or when enable bit 1 rises while `thr_empty` is 1. Clearing enable bit 1 drops it.
- R9: A one-cycle `iid_rd` pulse clears the transmit-empty pending flag only if the byte reported transmit empty (low nibble 0x2) in that cycle. A read while another source is reported leaves the flag set.
- R10: A one-cycle `thr_wr` pulse clears the transmit-empty pending flag.
- R11: After reset, `irq` is 0 and the byte is 0x01. Both outputs follow a change on a level input on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | Buffered mode is on |
| irq_en | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line error, [3] modem change |
| line_err | input | 1 | Receive line error condition (level) |
| rx_ready | input | 1 | Received data available (level) |
| rx_timeout | input | 1 | Character timeout condition (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| modem_chg | input | 1 | Modem status changed (level) |
| iid_rd | input | 1 | Identification byte is being read (one-cycle strobe) |
| thr_wr | input | 1 | New character written to the transmitter (one-cycle strobe) |
| irq | output | 1 | Registered interrupt request |
| iid | output | 8 | Registered identification byte |

## Verification
The sources are first raised one at a time, with and without FIFO mode. This confirms each code and the mode bits, and shows that the timeout input is ignored outside FIFO mode. Next, sources are stacked from the least urgent upward and then removed from the most urgent downward, which exposes any error in the order between neighbouring classes. The enable masks are stepped so that a source with its enable bit cleared is shown to have no effect on `irq` or the byte. Transmit-empty is run through each of its sequences: set by an edge of the condition, set by the enable bit rising, cleared by a read, kept by a read made while a higher source is reported, and cleared by a write. This separates the pending flag's set rules from its clear rules.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and types for the interrupt identifier.
// Assumes an 8-bit identification byte and four interrupt classes.
package uart_irq_pkg;

    // Number of interrupt classes, one enable bit each.
    localparam int NUM_CLASS = 4;
    localparam int ID_W      = 8;

    // Class index, equal to the enable bit that gates it.
    localparam int CLS_RX  = 0;
    localparam int CLS_TX  = 1;
    localparam int CLS_LSR = 2;
    localparam int CLS_MSR = 3;

    // Reported source.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_LSR  = 3'd1,
        SRC_RDA  = 3'd2,
        SRC_TMO  = 3'd3,
        SRC_THR  = 3'd4,
        SRC_MSR  = 3'd5
    } src_t;

    // Low-nibble codes of the identification byte.
    localparam logic [3:0] CODE_NONE = 4'h1;
    localparam logic [3:0] CODE_LSR  = 4'h6;
    localparam logic [3:0] CODE_RDA  = 4'h4;
    localparam logic [3:0] CODE_TMO  = 4'hC;
    localparam logic [3:0] CODE_THR  = 4'h2;
    localparam logic [3:0] CODE_MSR  = 4'h0;

    // Maps a source to its low nibble.
    function automatic logic [3:0] src_code(input src_t s);
        case (s)
            SRC_LSR: src_code = CODE_LSR;
            SRC_RDA: src_code = CODE_RDA;
            SRC_TMO: src_code = CODE_TMO;
            SRC_THR: src_code = CODE_THR;
            SRC_MSR: src_code = CODE_MSR;
            default: src_code = CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_thre_track.sv
// Module: holds the transmit-empty interrupt as a pending flag.
// Sets on a rising empty condition while enabled, or on the enable rising
// while empty. Clears on a character write, on a read of the identification
// byte while it reports transmit empty, or when the enable drops.
// Assumes iid_rd and thr_wr are one-cycle strobes in the clk domain.
module uart_irq_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic thr_empty,
    input  logic iid_rd,
    input  logic thr_wr,
    input  logic tx_reported,
    output logic pend
);
    logic empty_q;
    logic en_q;
    logic set_evt;
    logic clr_evt;

    // Edge memory for the empty condition and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= tx_en;
        end
    end

    // Set and clear events for the pending flag.
    always_comb begin
        set_evt = tx_en && ((thr_empty && !empty_q) || (thr_empty && !en_q));
        clr_evt = thr_wr || (iid_rd && tx_reported) || !tx_en;
    end

    // Pending flag; a clear wins over a set in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (clr_evt)  pend <= 1'b0;
        else if (set_evt)  pend <= 1'b1;
    end
endmodule

// File: rtl/uart_irq_prio_enc.sv
// Module: fixed-priority selection of the reported source.
// Takes gated class requests and picks the most urgent one. Within the
// receive class the timeout takes precedence over plain data ready.
// Purely combinational.
module uart_irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_CLASS
) (
    input  logic [N-1:0] req,
    input  logic         tmo_hit,
    output src_t         src
);
    // Class order from least to most urgent.
    localparam int ORDER [4] = '{CLS_MSR, CLS_TX, CLS_RX, CLS_LSR};

    // Map a class index to its source.
    function automatic src_t cls_src(input int c, input logic tmo);
        case (c)
            CLS_LSR: cls_src = SRC_LSR;
            CLS_RX:  cls_src = tmo ? SRC_TMO : SRC_RDA;
            CLS_TX:  cls_src = SRC_THR;
            default: cls_src = SRC_MSR;
        endcase
    endfunction

    // Walk from least to most urgent; the last match wins.
    always_comb begin
        src = SRC_NONE;
        for (int i = 0; i < N; i++) begin
            if (req[ORDER[i]]) src = cls_src(ORDER[i], tmo_hit);
        end
    end
endmodule

// File: rtl/uart_irq_id_reg.sv
// Module: formats and registers the identification byte and request line.
// Bit 0 is active low, bits 5:4 are zero, bits 7:6 mirror FIFO mode.
module uart_irq_id_reg
    import uart_irq_pkg::*;
#(
    parameter int W = ID_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  src_t         src,
    input  logic         fifo_mode,
    output logic         irq,
    output logic [W-1:0] iid
);
    localparam int MODE_W = W - 6;

    logic [W-1:0] iid_d;

    // Assemble the next identification byte.
    always_comb begin
        iid_d        = '0;
        iid_d[3:0]   = src_code(src);
        iid_d[W-1:6] = {MODE_W{fifo_mode}};
    end

    // Output registers, reset to "nothing pending".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            iid <= W'(CODE_NONE);
        end else begin
            irq <= (src != SRC_NONE);
            iid <= iid_d;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Module: top of the interrupt identifier.
// Gates the condition inputs with their enables, tracks transmit-empty as
// a pending event, selects the most urgent source and registers the result.
// Assumes all inputs are synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_mode,
    input  logic [NUM_CLASS-1:0] irq_en,
    input  logic                 line_err,
    input  logic                 rx_ready,
    input  logic                 rx_timeout,
    input  logic                 thr_empty,
    input  logic                 modem_chg,
    input  logic                 iid_rd,
    input  logic                 thr_wr,
    output logic                 irq,
    output logic [ID_W-1:0]      iid
);
    logic [NUM_CLASS-1:0] raw;
    logic [NUM_CLASS-1:0] req;
    logic                 tmo_hit;
    logic                 thr_pend;
    logic                 tx_reported;
    src_t                 src;

    // Timeout counts only in FIFO mode.
    always_comb tmo_hit = rx_timeout && fifo_mode;

    // Ungated class conditions, indexed like the enables.
    always_comb begin
        raw          = '0;
        raw[CLS_RX]  = rx_ready || tmo_hit;
        raw[CLS_TX]  = thr_pend;
        raw[CLS_LSR] = line_err;
        raw[CLS_MSR] = modem_chg;
    end

    // One gate per class.
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_gate
        always_comb req[g] = raw[g] && irq_en[g];
    end

    // Transmit empty is what the byte currently shows.
    always_comb tx_reported = (iid[3:0] == CODE_THR) && !iid[0];

    uart_irq_thre_track u_thre (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (irq_en[CLS_TX]),
        .thr_empty   (thr_empty),
        .iid_rd      (iid_rd),
        .thr_wr      (thr_wr),
        .tx_reported (tx_reported),
        .pend        (thr_pend)
    );

    uart_irq_prio_enc #(.N(NUM_CLASS)) u_prio (
        .req     (req),
        .tmo_hit (tmo_hit),
        .src     (src)
    );

    uart_irq_id_reg #(.W(ID_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .fifo_mode (fifo_mode),
        .irq       (irq),
        .iid       (iid)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker: timing properties of the interrupt identifier, bound to the top.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode,
    input logic [3:0] irq_en,
    input logic       line_err,
    input logic       rx_timeout,
    input logic       thr_wr,
    input logic       irq,
    input logic [7:0] iid
);
    // R2: request line and pending bit agree.
    assert_irq_vs_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iid[0]);

    // R5: reserved bits stay low.
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iid[5:4] == 2'b00);

    // R6: mode bits follow the FIFO flag one edge later.
    assert_mode_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |=> iid[7:6] == 2'b11);
    assert_mode_bits_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> iid[7:6] == 2'b00);

    // R4: timeout code appears only with FIFO mode bits set.
    assert_tmo_fifo_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iid[3] |-> (iid[7:6] == 2'b11 && iid[2]));

    // R1: an enabled line error always wins on the next edge.
    assert_lsr_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && irq_en[2]) |=> iid[3:0] == 4'h6);

    // R7: all enables off means nothing pending next edge.
    assert_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |=> (!irq && iid[0]));

    // R4: without FIFO mode a timeout alone cannot produce a timeout code.
    assert_no_tmo_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && rx_timeout) |=> !iid[3]);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .irq_en     (irq_en),
    .line_err   (line_err),
    .rx_timeout (rx_timeout),
    .thr_wr     (thr_wr),
    .irq        (irq),
    .iid        (iid)
);

// File: tb/uart_irq_ident_tb_top.sv
// Directed bench for the interrupt identifier.
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_mode;
    logic [3:0] irq_en;
    logic       line_err, rx_ready, rx_timeout, thr_empty, modem_chg;
    logic       iid_rd, thr_wr;
    logic       irq;
    logic [7:0] iid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .irq_en(irq_en),
        .line_err(line_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .modem_chg(modem_chg),
        .iid_rd(iid_rd), .thr_wr(thr_wr), .irq(irq), .iid(iid)
    );

    // Compare both outputs against expectations.
    task automatic check(input string req, input logic exp_irq, input logic [7:0] exp_iid);
        n_vec++;
        if (irq !== exp_irq || iid !== exp_iid) begin
            n_bad++;
            $display("FIFO-free miscompare line follows");
        end
    endtask

    task automatic chk(input string req, input logic exp_irq, input logic [7:0] exp_iid);
        n_vec++;
        if (irq !== exp_irq || iid !== exp_iid) begin
            n_bad++;
            $display("FAIL %s: irq=%0b iid=%02h expected irq=%0b iid=%02h",
                     req, irq, iid, exp_irq, exp_iid);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        line_err = 0; rx_ready = 0; rx_timeout = 0; thr_empty = 0; modem_chg = 0;
        iid_rd = 0; thr_wr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; fifo_mode = 0; irq_en = 4'h0; clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset", 1'b0, 8'h01);
    endtask

    task automatic t_latency();
        irq_en = 4'hF; line_err = 1;
        @(negedge clk);
        chk("R11 one-edge latency", 1'b1, 8'h06);
        line_err = 0;
        @(negedge clk);
        chk("R11 release latency", 1'b0, 8'h01);
    endtask

    task automatic t_singles();
        irq_en = 4'hF; fifo_mode = 0;
        line_err = 1; settle(); chk("R3 line error", 1, 8'h06); line_err = 0;
        rx_ready = 1; settle(); chk("R3 data ready", 1, 8'h04); rx_ready = 0;
        modem_chg = 1; settle(); chk("R3 modem", 1, 8'h00); modem_chg = 0;
        settle(); chk("R3 none", 0, 8'h01);
        fifo_mode = 1;
        settle(); chk("R6 fifo idle", 0, 8'hC1);
        rx_ready = 1; settle(); chk("R6 fifo data ready", 1, 8'hC4); rx_ready = 0;
        fifo_mode = 0; settle(); chk("R5 R6 back to plain", 0, 8'h01);
    endtask

    task automatic t_timeout();
        irq_en = 4'hF; fifo_mode = 0; rx_timeout = 1;
        settle(); chk("R4 timeout ignored", 0, 8'h01);
        fifo_mode = 1;
        settle(); chk("R4 timeout in fifo", 1, 8'hCC);
        rx_ready = 1;
        settle(); chk("R4 timeout over data ready", 1, 8'hCC);
        rx_timeout = 0;
        settle(); chk("R4 data ready after timeout", 1, 8'hC4);
        rx_ready = 0; fifo_mode = 0;
        settle();
    endtask

    task automatic t_priority();
        irq_en = 4'hF; fifo_mode = 0;
        modem_chg = 1; settle(); chk("R1 modem only", 1, 8'h00);
        thr_empty = 1; settle(); chk("R1 tx over modem", 1, 8'h02);
        rx_ready = 1;  settle(); chk("R1 rx over tx", 1, 8'h04);
        line_err = 1;  settle(); chk("R1 lsr over rx", 1, 8'h06);
        line_err = 0;  settle(); chk("R1 rx after lsr", 1, 8'h04);
        rx_ready = 0;  settle(); chk("R1 tx after rx", 1, 8'h02);
        thr_wr = 1; @(negedge clk); thr_wr = 0;
        settle(); chk("R10 write clears tx", 1, 8'h00);
        modem_chg = 0; thr_empty = 0; settle(); chk("R1 all gone", 0, 8'h01);
    endtask

    task automatic t_enables();
        fifo_mode = 0; irq_en = 4'h0;
        line_err = 1; rx_ready = 1; modem_chg = 1;
        settle(); chk("R7 all disabled", 0, 8'h01);
        fifo_mode = 1; settle(); chk("R7 all disabled fifo", 0, 8'hC1);
        fifo_mode = 0;
        irq_en = 4'b1000; settle(); chk("R7 modem only enabled", 1, 8'h00);
        irq_en = 4'b1001; settle(); chk("R7 rx enabled", 1, 8'h04);
        irq_en = 4'b0100; settle(); chk("R7 lsr enabled", 1, 8'h06);
        line_err = 0; rx_ready = 0; modem_chg = 0; irq_en = 4'h0;
        settle();
    endtask

    task automatic t_thre();
        fifo_mode = 0; irq_en = 4'b0010; thr_empty = 0;
        settle();
        thr_empty = 1; settle(); chk("R8 rising empty sets", 1, 8'h02);
        iid_rd = 1; @(negedge clk); iid_rd = 0;
        settle(); chk("R9 read clears tx", 0, 8'h01);
        irq_en = 4'b0000; settle();
        irq_en = 4'b0010; settle(); chk("R8 enable rise sets", 1, 8'h02);
        irq_en = 4'b0000; settle(); chk("R8 disable drops", 0, 8'h01);
        irq_en = 4'b0110; settle();
        line_err = 1; settle(); chk("R9 lsr reported", 1, 8'h06);
        iid_rd = 1; @(negedge clk); iid_rd = 0;
        line_err = 0;
        settle(); chk("R9 read of other keeps tx", 1, 8'h02);
        thr_wr = 1; @(negedge clk); thr_wr = 0;
        settle(); chk("R10 write clears", 0, 8'h01);
        thr_empty = 0; irq_en = 4'h0; settle();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_singles();
        t_timeout();
        t_priority();
        t_enables();
        t_thre();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule